// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block behaves like a small serial EEPROM as seen from its four bus pins. A host raises select, toggles the serial clock and shifts in a start bit, a two-bit opcode and an address, most significant bit first. Depending on the opcode, the block returns a word, takes in a data word, or arms a modifying operation. An organization input chooses between 8-bit and 16-bit words, and the address field gets one bit longer or shorter to match. The pins are oversampled by the system clock through a configurable synchronizer, so the serial clock must stay well below the system clock.

Each modifying instruction (write, erase, fill-all and clear-all) is held until select falls. It then runs a self-timed programming cycle whose length in system clocks is a parameter. While that cycle runs, the bus is ignored and the data output reports busy whenever select is high. Once the cycle ends, the output reports ready. A write-enable latch, which is cleared at reset and set and cleared by two instructions of their own, must be set before any modifying instruction takes effect. Storage is a byte array. In 16-bit mode, word `w` is bytes `2w` (bits 7:0) and `2w+1` (bits 15:8) of the 8-bit view.

Top module: `mw_serial_eeprom`

## Requirements
- R1: A frame starts when a 1 is sampled on a rising serial-clock edge with select high and no cycle running. Two opcode bits follow, then the address MSB first: ADDR_W16 bits in 16-bit mode (org_wide=1) and ADDR_W16+1 bits in 8-bit mode.
- R2: Opcode 10 (read) drives a dummy 0, enabled, right after the last address bit. Each later rising edge then presents the next bit of the addressed word, MSB first.
- R3: Clocking on past the end of a read word continues with the next address and wraps from the top address to zero.
- R4: Opcode 01 (write) takes one data word (8 or 16 bits, MSB first) and stores it when its cycle ends. In 16-bit mode, word w maps to byte 2w (bits 7:0) and byte 2w+1 (bits 15:8).
- R5: Opcode 11 (erase) sets the addressed word to all ones. Opcode 00 with top address bits 10 (clear-all) sets every byte to all ones.
- R6: Opcode 00 with top address bits 01 (fill-all) ignores the remaining address bits, takes one data word and writes it into every location.
- R7: The write-enable latch is cleared by reset and by opcode 00 with top bits 00, and set by opcode 00 with top bits 11. With the latch clear, a modifying instruction starts no cycle and changes no data.
- R8: The programming cycle starts on the falling edge of select after a complete modifying frame, and lasts exactly PROG_TICKS system clocks.
- R9: During the cycle, the output is enabled and drives 0 whenever select is high, and all serial input (including latch instructions) is ignored.
- R10: After the cycle, with select high, the output drives 1 until select falls or a new start bit is decoded. After that, the status is no longer shown.
- R11: The output enable is low whenever select is low.
- R12: After reset every byte reads as 0xFF and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| sdo | output | 1 | Serial data / status output |
| sdo_en | output | 1 | Output enable for sdo (0 means high impedance) |

## Verification
The bench goes after the places where width switching can slip. It reads the same bytes in both organizations, so a swapped byte order inside a 16-bit word, or an address field one bit too long or short, shows up as the wrong data. A sequential read that starts at the top address must come back around to address zero, which catches a read pointer that stops or runs off the end. Latch instructions are sent while a cycle is still running, so a design that listens during busy would drop the write-enable latch and lose the next write. The bench also checks that ready drops at a fresh start bit and after select falls, which catches a status flag that is held too long or cleared too early, including on the select fall that starts the cycle.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_ARMED,
    ST_READ,
    ST_HOLD
  } eng_state_e;

  typedef enum logic [1:0] {
    PG_WRITE,
    PG_ERASE,
    PG_FILL,
    PG_CLEAR
  } prog_op_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_CLEAR  = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_pin_sampler.sv
module mw_pin_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_pin,
  input  logic sclk_pin,
  input  logic sdi_pin,
  output logic sel_lvl,
  output logic sel_fall,
  output logic sclk_rise,
  output logic sdi_bit
);

  logic [STAGES-1:0][2:0] sync_q;
  logic                   sel_d_q;
  logic                   sclk_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      sel_d_q  <= 1'b0;
      sclk_d_q <= 1'b0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        sync_q[i] <= sync_q[i-1];
      end
      sync_q[0] <= {sel_pin, sclk_pin, sdi_pin};
      sel_d_q   <= sync_q[STAGES-1][2];
      sclk_d_q  <= sync_q[STAGES-1][1];
    end
  end

  assign sel_lvl   = sync_q[STAGES-1][2];
  assign sdi_bit   = sync_q[STAGES-1][0];
  assign sclk_rise = sync_q[STAGES-1][1] & ~sclk_d_q;
  assign sel_fall  = ~sync_q[STAGES-1][2] & sel_d_q;

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int unsigned TICKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit
);

  localparam int CNT_W = $clog2(TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (start) begin
      cnt_d = CNT_W'(TICKS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy   = (cnt_q != '0);
  assign commit = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_eeprom_pkg::*;
#(
  parameter int ABW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  prog_op_e       op,
  input  logic           wide,
  input  logic [ABW-1:0] addr,
  input  logic [15:0]    wdata,
  input  logic [ABW-1:0] rd_addr,
  input  logic           rd_wide,
  output logic [15:0]    rd_word
);

  localparam int NB = 1 << ABW;

  logic [NB-1:0][7:0] cells;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam logic [ABW-1:0] IDX = ABW'(g);
    logic       hit;
    logic [7:0] val;
    logic [7:0] cell_q;

    always_comb begin
      if (op == PG_FILL || op == PG_CLEAR) begin
        hit = 1'b1;
      end else if (wide) begin
        hit = (IDX[ABW-1:1] == addr[ABW-1:1]);
      end else begin
        hit = (IDX == addr);
      end
      if (op == PG_ERASE || op == PG_CLEAR) begin
        val = 8'hFF;
      end else if (wide && IDX[0]) begin
        val = wdata[15:8];
      end else begin
        val = wdata[7:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= 8'hFF;
      end else if (commit && hit) begin
        cell_q <= val;
      end
    end

    assign cells[g] = cell_q;
  end

  always_comb begin
    if (rd_wide) begin
      rd_word = {cells[{rd_addr[ABW-1:1], 1'b1}], cells[{rd_addr[ABW-1:1], 1'b0}]};
    end else begin
      rd_word = {cells[rd_addr], 8'h00};
    end
  end

endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W16 = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_lvl,
  input  logic                sel_fall,
  input  logic                sclk_rise,
  input  logic                sdi_bit,
  input  logic                org_wide,
  input  logic                busy,
  input  logic [15:0]         rd_word,
  output logic                start,
  output prog_op_e            pend_op,
  output logic                pend_wide,
  output logic [ADDR_W16:0]   pend_addr,
  output logic [15:0]         pend_data,
  output logic [ADDR_W16:0]   rd_addr,
  output logic                wen,
  output logic                sdo,
  output logic                sdo_en
);

  localparam int ABW = ADDR_W16 + 1;
  localparam int CW  = ABW + 2;
  localparam int BCW = $clog2(((CW > 16) ? CW : 16) + 1);

  eng_state_e     state_q, state_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [CW-2:0]  cmd_q, cmd_d;
  logic           wide_q, wide_d;
  logic           wen_q, wen_d;
  logic           status_q, status_d;
  logic           rbit_q, rbit_d;
  logic [15:0]    rsh_q, rsh_d;
  logic [ABW-1:0] raddr_q, raddr_d;
  prog_op_e       pop_q, pop_d;
  logic [ABW-1:0] paddr_q, paddr_d;
  logic [15:0]    pdata_q, pdata_d;

  logic [CW-1:0]  full;
  logic [1:0]     op_w;
  logic [1:0]     ext_w;
  logic [ABW-1:0] addr_w;
  logic           cmd_last;
  logic [BCW-1:0] dw_last;

  always_comb begin
    full     = {cmd_q, sdi_bit};
    op_w     = wide_q ? full[ADDR_W16+1:ADDR_W16] : full[ADDR_W16+2:ADDR_W16+1];
    ext_w    = wide_q ? full[ADDR_W16-1:ADDR_W16-2] : full[ADDR_W16:ADDR_W16-1];
    addr_w   = wide_q ? {full[ADDR_W16-1:0], 1'b0} : full[ADDR_W16:0];
    cmd_last = (bcnt_q == (wide_q ? BCW'(CW - 2) : BCW'(CW - 1)));
    dw_last  = wide_q ? BCW'(15) : BCW'(7);
  end

  always_comb begin
    state_d  = state_q;
    bcnt_d   = bcnt_q;
    cmd_d    = cmd_q;
    wide_d   = wide_q;
    wen_d    = wen_q;
    status_d = status_q;
    rbit_d   = rbit_q;
    rsh_d    = rsh_q;
    raddr_d  = raddr_q;
    pop_d    = pop_q;
    paddr_d  = paddr_q;
    pdata_d  = pdata_q;
    start    = 1'b0;
    if (!busy) begin
      if (!sel_lvl) begin
        state_d = ST_IDLE;
        if (sel_fall) begin
          status_d = 1'b0;
          if (state_q == ST_ARMED && wen_q) begin
            start    = 1'b1;
            status_d = 1'b1;
          end
        end
      end else if (sclk_rise) begin
        unique case (state_q)
          ST_IDLE: begin
            if (sdi_bit) begin
              state_d  = ST_CMD;
              bcnt_d   = '0;
              wide_d   = org_wide;
              status_d = 1'b0;
            end
          end
          ST_CMD: begin
            cmd_d  = full[CW-2:0];
            bcnt_d = bcnt_q + 1'b1;
            if (cmd_last) begin
              bcnt_d = '0;
              unique case (op_w)
                OPC_READ: begin
                  state_d = ST_READ;
                  raddr_d = addr_w;
                  rbit_d  = 1'b0;
                end
                OPC_WRITE: begin
                  state_d = ST_DATA;
                  pop_d   = PG_WRITE;
                  paddr_d = addr_w;
                end
                OPC_ERASE: begin
                  state_d = ST_ARMED;
                  pop_d   = PG_ERASE;
                  paddr_d = addr_w;
                end
                default: begin
                  unique case (ext_w)
                    EXT_UNLOCK: begin
                      wen_d   = 1'b1;
                      state_d = ST_HOLD;
                    end
                    EXT_LOCK: begin
                      wen_d   = 1'b0;
                      state_d = ST_HOLD;
                    end
                    EXT_FILL: begin
                      pop_d   = PG_FILL;
                      state_d = ST_DATA;
                    end
                    default: begin
                      pop_d   = PG_CLEAR;
                      state_d = ST_ARMED;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            pdata_d = {pdata_q[14:0], sdi_bit};
            bcnt_d  = bcnt_q + 1'b1;
            if (bcnt_q == dw_last) begin
              bcnt_d  = '0;
              state_d = ST_ARMED;
            end
          end
          ST_READ: begin
            if (bcnt_q == '0) begin
              rbit_d = rd_word[15];
              rsh_d  = {rd_word[14:0], 1'b0};
            end else begin
              rbit_d = rsh_q[15];
              rsh_d  = {rsh_q[14:0], 1'b0};
            end
            if (bcnt_q == dw_last) begin
              bcnt_d  = '0;
              raddr_d = raddr_q + (wide_q ? ABW'(2) : ABW'(1));
            end else begin
              bcnt_d = bcnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bcnt_q   <= '0;
      cmd_q    <= '0;
      wide_q   <= 1'b0;
      wen_q    <= 1'b0;
      status_q <= 1'b0;
      rbit_q   <= 1'b0;
      rsh_q    <= '0;
      raddr_q  <= '0;
      pop_q    <= PG_WRITE;
      paddr_q  <= '0;
      pdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      bcnt_q   <= bcnt_d;
      cmd_q    <= cmd_d;
      wide_q   <= wide_d;
      wen_q    <= wen_d;
      status_q <= status_d;
      rbit_q   <= rbit_d;
      rsh_q    <= rsh_d;
      raddr_q  <= raddr_d;
      pop_q    <= pop_d;
      paddr_q  <= paddr_d;
      pdata_q  <= pdata_d;
    end
  end

  assign pend_op   = pop_q;
  assign pend_wide = wide_q;
  assign pend_addr = paddr_q;
  assign pend_data = pdata_q;
  assign rd_addr   = raddr_q;
  assign wen       = wen_q;
  assign sdo       = status_q ? ~busy : rbit_q;
  assign sdo_en    = sel_lvl && (status_q || state_q == ST_READ);

endmodule

// File: rtl/mw_serial_eeprom.sv
module mw_serial_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int          ADDR_W16    = 6,
  parameter int unsigned PROG_TICKS  = 250000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  input  logic org_wide,
  output logic sdo,
  output logic sdo_en
);

  localparam int ABW = ADDR_W16 + 1;

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           sel_lvl, sel_fall, sclk_rise, sdi_bit;
  logic           busy, commit, prog_start, wen;
  prog_op_e       pend_op;
  logic           pend_wide;
  logic [ABW-1:0] pend_addr, rd_addr;
  logic [15:0]    pend_data, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  mw_pin_sampler #(.STAGES(SYNC_STAGES)) u_pins (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_pin  (sel),
    .sclk_pin (sclk),
    .sdi_pin  (sdi),
    .sel_lvl  (sel_lvl),
    .sel_fall (sel_fall),
    .sclk_rise(sclk_rise),
    .sdi_bit  (sdi_bit)
  );

  mw_cmd_engine #(.ADDR_W16(ADDR_W16)) u_engine (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_lvl  (sel_lvl),
    .sel_fall (sel_fall),
    .sclk_rise(sclk_rise),
    .sdi_bit  (sdi_bit),
    .org_wide (org_wide),
    .busy     (busy),
    .rd_word  (rd_word),
    .start    (prog_start),
    .pend_op  (pend_op),
    .pend_wide(pend_wide),
    .pend_addr(pend_addr),
    .pend_data(pend_data),
    .rd_addr  (rd_addr),
    .wen      (wen),
    .sdo      (sdo),
    .sdo_en   (sdo_en)
  );

  mw_prog_timer #(.TICKS(PROG_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (prog_start),
    .busy  (busy),
    .commit(commit)
  );

  mw_array #(.ABW(ABW)) u_array (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .commit (commit),
    .op     (pend_op),
    .wide   (pend_wide),
    .addr   (pend_addr),
    .wdata  (pend_data),
    .rd_addr(rd_addr),
    .rd_wide(pend_wide),
    .rd_word(rd_word)
  );

endmodule

// File: rtl/mw_serial_eeprom_chk.sv
module mw_serial_eeprom_chk #(
  parameter int unsigned PROG_TICKS = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sel_fall,
  input logic sel_lvl,
  input logic wen,
  input logic sdo,
  input logic sdo_en
);

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= 0;
    end else if (busy) begin
      busy_run <= busy_run + 1;
    end else begin
      busy_run <= 0;
    end
  end

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == PROG_TICKS));

  assert_start_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sel_fall));

  assert_start_needs_wen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  assert_busy_drives_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdo_en) |-> !sdo);

  assert_wen_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wen));

  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && sdo_en) |-> sdo);

  assert_oe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_lvl |-> !sdo_en);

endmodule

bind mw_serial_eeprom mw_serial_eeprom_chk #(.PROG_TICKS(PROG_TICKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .sel_fall(sel_fall),
  .sel_lvl (sel_lvl),
  .wen     (wen),
  .sdo     (sdo),
  .sdo_en  (sdo_en)
);

// File: tb/tb_mw_serial_eeprom.sv
module tb_mw_serial_eeprom;

  localparam int AW16  = 6;
  localparam int NB    = 1 << (AW16 + 1);
  localparam int TICKS = 200;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n, sel, sclk, sdi, org_wide;
  logic sdo, sdo_en;

  int errs = 0;
  int checks = 0;
  logic [7:0] model [NB];
  bit model_wen;

  always #10 clk = ~clk;

  mw_serial_eeprom #(.ADDR_W16(AW16), .PROG_TICKS(TICKS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .org_wide(org_wide), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mword(bit w, int a);
    if (w) return {model[2*a+1], model[2*a]};
    return int'(model[a]);
  endfunction

  task automatic m_write(bit w, int a, int d, bit erase);
    logic [15:0] v;
    if (!model_wen) return;
    v = erase ? 16'hFFFF : d[15:0];
    if (w) begin
      model[2*a]   = v[7:0];
      model[2*a+1] = v[15:8];
    end else begin
      model[a] = v[7:0];
    end
  endtask

  task automatic m_fill(bit w, int d);
    if (!model_wen) return;
    for (int i = 0; i < NB; i++) model[i] = (w && (i % 2 == 1)) ? d[15:8] : d[7:0];
  endtask

  task automatic pulse(input bit b, output bit q);
    @(negedge clk);
    sdi = b; sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    q = sdo;
  endtask

  task automatic sel_on();
    @(negedge clk);
    sclk = 1'b0; sel = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk);
    sclk = 1'b0; sel = 1'b0; sdi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic int ext_addr(bit w, int e);
    return w ? (e << (AW16 - 2)) : (e << (AW16 - 1));
  endfunction

  task automatic frame_bits(input bit w, input bit [1:0] op, input int a, output bit q);
    bit qq;
    int n;
    org_wide = w;
    n = w ? AW16 : AW16 + 1;
    pulse(1'b1, qq);
    pulse(op[1], qq);
    pulse(op[0], qq);
    for (int i = n - 1; i >= 0; i--) pulse(a[i], qq);
    q = qq;
  endtask

  task automatic send_frame(input bit w, input bit [1:0] op, input int a, output bit q);
    sel_on();
    frame_bits(w, op, a, q);
  endtask

  task automatic send_data(bit w, int d);
    bit q;
    for (int i = (w ? 15 : 7); i >= 0; i--) pulse(d[i], q);
  endtask

  // R8/R9/R10/R11: poll a programming cycle after the frame, or confirm none ran (R7)
  task automatic finish_prog(bit expect_run);
    sel_off();
    sel_on();
    if (!expect_run) begin
      check("R7", "no cycle when latch clear, sdo_en", int'(sdo_en), 0);
      sel_off();
      return;
    end
    check("R9", "busy status {en,sdo}", {sdo_en, sdo}, 2'b10);
    repeat (TICKS - 14) @(negedge clk);
    check("R8", "still busy near end {en,sdo}", {sdo_en, sdo}, 2'b10);
    repeat (12) @(negedge clk);
    check("R10", "ready after cycle {en,sdo}", {sdo_en, sdo}, 2'b11);
    repeat (20) @(negedge clk);
    check("R10", "ready held {en,sdo}", {sdo_en, sdo}, 2'b11);
    sel_off();
    check("R11", "sdo_en with select low", int'(sdo_en), 0);
    sel_on();
    check("R10", "status gone after select fall, sdo_en", int'(sdo_en), 0);
    sel_off();
  endtask

  task automatic do_read(bit w, int a, int nwords, string req);
    bit q;
    int v;
    int span;
    span = w ? (NB / 2) : NB;
    send_frame(w, 2'b10, a, q);
    check("R2", "dummy bit", int'(q), 0);
    check("R2", "read output enable", int'(sdo_en), 1);
    for (int k = 0; k < nwords; k++) begin
      v = 0;
      for (int b = 0; b < (w ? 16 : 8); b++) begin
        pulse(1'b0, q);
        v = (v << 1) | int'(q);
      end
      check(req, $sformatf("read org=%0d addr=%0d", w, (a + k) % span), v, mword(w, (a + k) % span));
    end
    sel_off();
  endtask

  task automatic do_write(bit w, int a, int d);
    bit q;
    send_frame(w, 2'b01, a, q);
    send_data(w, d);
    m_write(w, a, d, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit q;
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    model_wen = 1'b0;
    rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0; org_wide = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12", "sdo_en after reset", int'(sdo_en), 0);
    do_read(1'b1, 0, 1, "R12");

    // R7: write with latch clear is dropped
    do_write(1'b1, 5, 16'h1234);
    finish_prog(1'b0);
    do_read(1'b1, 5, 1, "R7");

    // R7: unlock
    send_frame(1'b1, 2'b00, ext_addr(1'b1, 3), q);
    sel_off();
    model_wen = 1'b1;

    // R4: x16 write, then the byte view (R1 address width per mode, R3 sequence)
    do_write(1'b1, 5, 16'hA5C3);
    finish_prog(1'b1);
    do_read(1'b1, 5, 1, "R4");
    do_read(1'b0, 10, 2, "R4");

    // R1/R4: x8 write
    do_write(1'b0, 20, 8'h3C);
    finish_prog(1'b1);
    do_read(1'b0, 20, 1, "R1");
    do_read(1'b1, 10, 1, "R4");

    // R3: wrap from the top word to zero
    do_write(1'b1, 63, 16'h7E81);
    finish_prog(1'b1);
    do_read(1'b1, 63, 2, "R3");

    // R5: erase one word
    send_frame(1'b1, 2'b11, 5, q);
    m_write(1'b1, 5, 0, 1'b1);
    finish_prog(1'b1);
    do_read(1'b1, 5, 1, "R5");

    // R6: fill all in x8 mode, dummy low address bits set
    send_frame(1'b0, 2'b00, ext_addr(1'b0, 1) | 5, q);
    send_data(1'b0, 8'h5A);
    m_fill(1'b0, 8'h5A);
    finish_prog(1'b1);
    do_read(1'b1, 7, 1, "R6");
    do_read(1'b0, 100, 1, "R6");

    // R6: fill all in x16 mode
    send_frame(1'b1, 2'b00, ext_addr(1'b1, 1), q);
    send_data(1'b1, 16'hC031);
    m_fill(1'b1, 16'hC031);
    finish_prog(1'b1);
    do_read(1'b0, 41, 2, "R6");

    // R5: clear all
    send_frame(1'b1, 2'b00, ext_addr(1'b1, 2), q);
    m_fill(1'b1, 16'hFFFF);
    finish_prog(1'b1);
    do_read(1'b1, 30, 1, "R5");

    // R9: a lock frame sent during busy is ignored
    do_write(1'b1, 9, 16'hBEEF);
    sel_off();
    sel_on();
    frame_bits(1'b1, 2'b00, ext_addr(1'b1, 0), q);
    check("R9", "sdo during busy frame", int'(q), 0);
    repeat (TICKS - 68) @(negedge clk);
    check("R10", "ready after busy frame {en,sdo}", {sdo_en, sdo}, 2'b11);
    sel_off();
    do_write(1'b1, 10, 16'h1357);
    finish_prog(1'b1);
    do_read(1'b1, 9, 2, "R9");

    // R10: a new start bit removes the ready status
    do_write(1'b1, 12, 16'h0F0F);
    sel_off();
    sel_on();
    repeat (TICKS + 10) @(negedge clk);
    check("R10", "ready before start bit", int'(sdo), 1);
    pulse(1'b1, q);
    check("R10", "sdo_en after start bit", int'(sdo_en), 0);
    sel_off();
    do_read(1'b1, 12, 1, "R4");

    // R7: lock, then a write is ignored
    send_frame(1'b0, 2'b00, ext_addr(1'b0, 0), q);
    sel_off();
    model_wen = 1'b0;
    do_write(1'b1, 12, 16'h2222);
    finish_prog(1'b0);
    do_read(1'b1, 12, 1, "R7");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule